// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of an asynchronous flash read bus. It decides whether an erase or program that was started earlier has finished. After a start request it reads the device status byte again and again. It compares a toggle bit across consecutive reads. When that bit stops changing, the block reports completion.

While the bit keeps changing, the block looks at the device's error flag:

- **Error flag clear:** the block keeps polling, up to a parameterised number of reads. If that count runs out, it reports a host-side timeout.
- **Error flag set:** the block makes one more pair of reads to confirm. If the bit is still changing, it writes the reset word to the device and then reports failure.

Every bus access is a strobe. Chip enable and either output enable (for a read) or write enable (for the reset write) stay low for a programmable number of cycles. A programmable recovery time with all strobes high follows. The bank address is taken once at start and never moves while chip enable is low.

Top module: `tbit_poll_ctrl`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, and `busy`, `done`, `fail` and `tmo` are low.
- R2: A `start` sampled while idle latches `poll_addr` onto `bus_addr` and raises `busy`. `bus_addr` changes only in a cycle in which `bus_ce_n` is high and was also high in the cycle before.
- R3: A status read holds `bus_ce_n` and `bus_oe_n` low together for exactly LOW_CYC cycles, with `bus_we_n` high. After each access, all strobes stay high for REC_CYC cycles plus one issue cycle before the next access begins.
- R4: The toggle bit is bit TOG_BIT of the status byte (default 6). At least two reads are made before any result. If the bit has the same value in two compared reads, `done` pulses. With default timing, two reads give `done` in the 13th cycle after the start edge.
- R5: If the bit changed and the error flag is 0, polling continues. The error flag is bit ERR_BIT of the status byte (default 5). Each new read is compared with the read just before it.
- R6: If the bit changed and the error flag is 1, two further reads are made, and the first of them becomes the new reference. If those two reads agree, `done` pulses and no write takes place.
- R7: If the two confirming reads disagree, a write cycle follows. In it, `bus_ce_n` and `bus_we_n` are low for LOW_CYC cycles, `bus_oe_n` is high, `bus_dout` equals RST_WORD and the address is the held bank address. `fail` pulses after the write's recovery.
- R8: If MAX_READS reads complete with the bit still changing and the error flag 0, `tmo` pulses and no write is issued.
- R9: `done`, `fail` and `tmo` each last one cycle, and at most one of them is high in any cycle.
- R10: A `start` arriving while `busy` is high is ignored. It changes neither `bus_addr` nor the number of reads, and it produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin polling |
| poll_addr | input | AW | Bank address to poll |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: operation complete |
| fail | output | 1 | One-cycle pulse: device failure, reset word written |
| tmo | output | 1 | One-cycle pulse: host read limit reached |
| bus_addr | output | AW | Address to the device |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dout | output | DW | Write data (reset word) |
| bus_din | input | DW | Status byte from the device |

## Verification
Each access costs 1 + LOW_CYC + REC_CYC cycles, so each access takes 6 cycles at the default timing. A result pulse appears in the cycle after the last access ends, so it comes at 6·k + 1 cycles after the start edge for k accesses. For example, `done` comes at cycle 13 after two reads, and `fail` at cycle 31 after four reads and the write. The bench counts falling edges from the cycle that follows the accepted `start`, and it samples every output at the falling clock edge. It compares the cycle in which the pulse appears with these figures. A status model in the bench counts reads, measures strobe widths and gaps, and captures the write data and address, so read counts and bus timing are checked at the ports.

// File: rtl/tbit_poll_pkg.sv
// Package: state encodings shared by the poller's submodules.
package tbit_poll_pkg;

    // Bus access sequencer phases.
    typedef enum logic [1:0] {
        BS_IDLE,
        BS_LOW,
        BS_REC
    } bus_st_t;

    // Polling decision machine states.
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_RD_REQ,
        PS_RD_WAIT,
        PS_WR_REQ,
        PS_WR_WAIT
    } poll_st_t;

endpackage

// File: rtl/tbit_bus_strobe.sv
// Module: tbit_bus_strobe
// Runs one asynchronous bus access per go pulse: a strobe-low phase of
// LOW_CYC cycles, then a recovery phase of REC_CYC cycles with every
// strobe high. For a read, the status is captured on the last low cycle.
// Assumes: go is only raised while idle; LOW_CYC >= 1 and REC_CYC >= 1.
module tbit_bus_strobe
    import tbit_poll_pkg::*;
#(
    parameter int DW      = 8,
    parameter int LOW_CYC = 3,
    parameter int REC_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] din,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rdata,
    output logic          cyc_done
);
    localparam int MAXC = (LOW_CYC > REC_CYC) ? LOW_CYC : REC_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    bus_st_t       st;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [DW-1:0] wdata_q;

    // Phase sequencing, read capture and write-data hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BS_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            case (st)
                BS_IDLE: begin
                    if (go) begin
                        st      <= BS_LOW;
                        cnt     <= '0;
                        wr_q    <= go_wr;
                        wdata_q <= wdata;
                    end
                end
                BS_LOW: begin
                    if (cnt == CW'(LOW_CYC - 1)) begin
                        if (!wr_q) rdata <= din;
                        st  <= BS_REC;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BS_REC: begin
                    if (cnt == CW'(REC_CYC - 1)) begin
                        st  <= BS_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= BS_IDLE;
            endcase
        end
    end

    // Strobes are decoded straight from the phase, so they are glitch-free per cycle.
    assign ce_n     = (st != BS_LOW);
    assign oe_n     = !((st == BS_LOW) && !wr_q);
    assign we_n     = !((st == BS_LOW) && wr_q);
    assign dout     = wr_q ? wdata_q : '0;
    assign cyc_done = (st == BS_REC) && (cnt == CW'(REC_CYC - 1));

endmodule

// File: rtl/tbit_poll_fsm.sv
// Module: tbit_poll_fsm
// Decides completion from consecutive status reads. The first read of a
// pair sets the reference. A steady toggle bit means done. A changing bit
// with the error flag set gets one confirming pair; if that pair also
// changes, the reset word is written. A changing bit with the flag clear
// keeps polling, up to MAX_READS reads.
// Assumes: the sequencer raises cyc_done once per issued access.
module tbit_poll_fsm
    import tbit_poll_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 8,
    parameter int TOG_BIT   = 6,
    parameter int ERR_BIT   = 5,
    parameter int MAX_READS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] rdata,
    input  logic          cyc_done,
    output logic          go,
    output logic          go_wr,
    output logic [AW-1:0] bus_addr,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          tmo
);
    localparam int RCW = $clog2(MAX_READS + 3);

    poll_st_t       st;
    logic [AW-1:0]  addr_q;
    logic [RCW-1:0] rd_cnt;
    logic [RCW-1:0] rd_num;
    logic           prev_tb;
    logic           have_ref;
    logic           confirm;
    logic           cur_tb;
    logic           cur_err;
    logic           done_q, fail_q, tmo_q;

    // Decode of the freshly captured status and the running read count.
    always_comb begin
        cur_tb  = rdata[TOG_BIT];
        cur_err = rdata[ERR_BIT];
        rd_num  = rd_cnt + 1'b1;
    end

    // Polling decisions, address hold and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_IDLE;
            addr_q   <= '0;
            rd_cnt   <= '0;
            prev_tb  <= 1'b0;
            have_ref <= 1'b0;
            confirm  <= 1'b0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (st)
                PS_IDLE: begin
                    if (start) begin
                        addr_q   <= addr_in;
                        rd_cnt   <= '0;
                        have_ref <= 1'b0;
                        confirm  <= 1'b0;
                        st       <= PS_RD_REQ;
                    end
                end
                PS_RD_REQ: st <= PS_RD_WAIT;
                PS_RD_WAIT: begin
                    if (cyc_done) begin
                        rd_cnt  <= rd_num;
                        prev_tb <= cur_tb;
                        if (!have_ref) begin
                            have_ref <= 1'b1;
                            st       <= PS_RD_REQ;
                        end else if (cur_tb == prev_tb) begin
                            done_q <= 1'b1;
                            st     <= PS_IDLE;
                        end else if (confirm) begin
                            st <= PS_WR_REQ;
                        end else if (cur_err) begin
                            confirm  <= 1'b1;
                            have_ref <= 1'b0;
                            st       <= PS_RD_REQ;
                        end else if (rd_num >= RCW'(MAX_READS)) begin
                            tmo_q <= 1'b1;
                            st    <= PS_IDLE;
                        end else begin
                            st <= PS_RD_REQ;
                        end
                    end
                end
                PS_WR_REQ: st <= PS_WR_WAIT;
                PS_WR_WAIT: begin
                    if (cyc_done) begin
                        fail_q <= 1'b1;
                        st     <= PS_IDLE;
                    end
                end
                default: st <= PS_IDLE;
            endcase
        end
    end

    assign go       = (st == PS_RD_REQ) || (st == PS_WR_REQ);
    assign go_wr    = (st == PS_WR_REQ);
    assign bus_addr = addr_q;
    assign busy     = (st != PS_IDLE);
    assign done     = done_q;
    assign fail     = fail_q;
    assign tmo      = tmo_q;

endmodule

// File: rtl/tbit_poll_ctrl.sv
// Module: tbit_poll_ctrl (top)
// Toggle-bit completion poller. It joins the decision machine to the
// bus access sequencer. The bank address changes only at start, and start
// is accepted only while idle with every strobe high.
// Assumes: the device drives bus_din while bus_ce_n and bus_oe_n are low.
module tbit_poll_ctrl #(
    parameter int          AW        = 20,
    parameter int          DW        = 8,
    parameter int          TOG_BIT   = 6,
    parameter int          ERR_BIT   = 5,
    parameter int          LOW_CYC   = 3,
    parameter int          REC_CYC   = 2,
    parameter int          MAX_READS = 256,
    parameter int unsigned RST_WORD  = 32'h0000_00F0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] poll_addr,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          tmo,
    output logic [AW-1:0] bus_addr,
    output logic          bus_ce_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din
);
    localparam logic [DW-1:0] RST_W = DW'(RST_WORD);

    logic          go, go_wr, cyc_done;
    logic [DW-1:0] rdata;

    tbit_poll_fsm #(
        .AW(AW), .DW(DW), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT),
        .MAX_READS(MAX_READS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(poll_addr),
        .rdata(rdata), .cyc_done(cyc_done), .go(go), .go_wr(go_wr),
        .bus_addr(bus_addr), .busy(busy), .done(done), .fail(fail), .tmo(tmo)
    );

    tbit_bus_strobe #(
        .DW(DW), .LOW_CYC(LOW_CYC), .REC_CYC(REC_CYC)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(go), .go_wr(go_wr), .wdata(RST_W),
        .din(bus_din), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
        .dout(bus_dout), .rdata(rdata), .cyc_done(cyc_done)
    );

endmodule

// File: rtl/tbit_poll_chk.sv
// Module: tbit_poll_chk
// Checker for the poller's port-level rules. It is bound to every
// instance of tbit_poll_ctrl.
module tbit_poll_chk #(
    parameter int AW      = 20,
    parameter int LOW_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          tmo,
    input logic [AW-1:0] bus_addr,
    input logic          bus_ce_n,
    input logic          bus_oe_n,
    input logic          bus_we_n
);
    localparam int LW = $clog2(LOW_CYC + 2);

    logic [LW-1:0] low_run;

    // Counts earlier consecutive cycles with chip enable low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_run <= '0;
        else if (bus_ce_n)                   low_run <= '0;
        else if (low_run != LW'(LOW_CYC + 1)) low_run <= low_run + 1'b1;
    end

    // R1
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_ce_n && bus_oe_n && bus_we_n));

    // R2
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_addr) |-> (bus_ce_n && $past(bus_ce_n)));

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce_n |-> (low_run < LW'(LOW_CYC)));

    // R3
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> (!bus_ce_n && (bus_oe_n || bus_we_n)));

    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, tmo}));

    // R9
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || tmo) |=> !(done || fail || tmo));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(bus_addr));

endmodule

bind tbit_poll_ctrl tbit_poll_chk #(.AW(AW), .LOW_CYC(LOW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .tmo(tmo), .bus_addr(bus_addr), .bus_ce_n(bus_ce_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n)
);

// File: tb/sim_tbit_poll_ctrl.sv
// Directed bench for tbit_poll_ctrl with a behavioural status model.
module sim_tbit_poll_ctrl;
    localparam int AW = 20, DW = 8, LOWC = 3, RECC = 2, MAXR = 8;
    localparam int ACC = 1 + LOWC + RECC;   // cycles per access
    localparam logic [7:0] RSTW = 8'hF0;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic          busy, done, fail, tmo;
    logic [AW-1:0] bus_addr;
    logic          bus_ce_n, bus_oe_n, bus_we_n;
    logic [DW-1:0] bus_dout, bus_din;

    int total = 0, bad = 0, wd = 0;

    // status model state
    logic m_tb = 1'b0, m_err = 1'b0;
    int   m_flips = 0, rd_count = 0, wr_count = 0;
    int   low_w = 0, last_low_w = 0, gap = 0, last_gap = -1;
    logic in_rd = 1'b0, in_wr = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] wr_addr = '0;
    int   res, lat;

    always #5 clk = ~clk;

    tbit_poll_ctrl #(.AW(AW), .DW(DW), .LOW_CYC(LOWC), .REC_CYC(RECC),
                     .MAX_READS(MAXR), .RST_WORD(32'hF0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
        .busy(busy), .done(done), .fail(fail), .tmo(tmo), .bus_addr(bus_addr),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    // Status byte layout: bit 6 toggle, bit 5 error flag.
    assign bus_din = {1'b0, m_tb, m_err, 5'b0};

    // Device model: counts accesses, measures strobe timing, captures writes.
    always @(negedge clk) begin
        if (!bus_ce_n) begin
            low_w = low_w + 1;
            if (gap > 0) last_gap = gap;
            gap = 0;
            if (!bus_oe_n) in_rd = 1'b1;
            if (!bus_we_n) begin
                in_wr = 1'b1; wr_data = bus_dout; wr_addr = bus_addr;
            end
        end else begin
            if (low_w > 0) last_low_w = low_w;
            low_w = 0;
            gap = gap + 1;
            if (in_rd) begin
                rd_count = rd_count + 1;
                if (m_flips > 0) begin m_tb = ~m_tb; m_flips = m_flips - 1; end
            end
            if (in_wr) wr_count = wr_count + 1;
            in_rd = 1'b0; in_wr = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 100000) begin
            total = total + 1; bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic err, input int flips);
        m_tb = 1'b0; m_err = err; m_flips = flips;
        rd_count = 0; wr_count = 0; last_gap = -1; gap = 0;
    endtask

    // Pulses start at a falling edge, then waits for a result. res: 1 done, 2 fail, 3 tmo.
    task automatic run(input logic [AW-1:0] a);
        poll_addr = a; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        res = 0; lat = 0;
        while (res == 0 && lat < 2000) begin
            @(negedge clk); lat = lat + 1;
            if (done) res = 1; else if (fail) res = 2; else if (tmo) res = 3;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 ce_n", bus_ce_n, 1); chk("R1 oe_n", bus_oe_n, 1);
        chk("R1 we_n", bus_we_n, 1); chk("R1 busy", busy, 0);
        chk("R1 pulses", {done, fail, tmo}, 0);
        rst_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_quick_done;
        setup(1'b0, 0);
        run(20'h1_2340);
        chk("R4 result", res, 1); chk("R4 latency", lat, 2*ACC + 1);
        chk("R4 reads", rd_count, 2); chk("R2 addr", bus_addr, 20'h1_2340);
        chk("R3 low width", last_low_w, LOWC); chk("R3 gap", last_gap, RECC + 1);
        @(negedge clk); chk("R9 done one cycle", done, 0);
    endtask

    task automatic t_keep_polling;
        setup(1'b0, 3);
        run(20'h0_0100);
        chk("R5 result", res, 1); chk("R5 reads", rd_count, 5);
        chk("R5 latency", lat, 5*ACC + 1); chk("R5 no write", wr_count, 0);
    endtask

    task automatic t_confirm_ok;
        setup(1'b1, 2);
        run(20'h0_0200);
        chk("R6 result", res, 1); chk("R6 reads", rd_count, 4);
        chk("R6 no write", wr_count, 0);
    endtask

    task automatic t_fail;
        setup(1'b1, 100);
        run(20'h3_0000);
        chk("R7 result", res, 2); chk("R7 reads", rd_count, 4);
        chk("R7 writes", wr_count, 1); chk("R7 word", wr_data, RSTW);
        chk("R7 addr", wr_addr, 20'h3_0000); chk("R7 write width", last_low_w, LOWC);
        chk("R7 latency", lat, 5*ACC + 1);
        @(negedge clk); chk("R9 fail one cycle", fail, 0);
    endtask

    task automatic t_host_tmo;
        setup(1'b0, 1000);
        run(20'h0_0300);
        chk("R8 result", res, 3); chk("R8 reads", rd_count, MAXR);
        chk("R8 no write", wr_count, 0); chk("R8 latency", lat, MAXR*ACC + 1);
        @(negedge clk); chk("R9 tmo one cycle", tmo, 0);
    endtask

    task automatic t_busy_start;
        int extra;
        setup(1'b0, 3);
        poll_addr = 20'h0_0AAA; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (8) @(negedge clk);
        poll_addr = 20'h0_0BBB; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R10 addr held", bus_addr, 20'h0_0AAA);
        res = 0;
        for (int i = 0; i < 200 && res == 0; i++) begin
            @(negedge clk);
            if (done) res = 1; else if (fail) res = 2; else if (tmo) res = 3;
        end
        chk("R10 result", res, 1); chk("R10 reads", rd_count, 5);
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done || fail || tmo) extra = extra + 1;
        end
        chk("R10 no extra result", extra, 0); chk("R10 idle", busy, 0);
        chk("R10 no extra reads", rd_count, 5);
    endtask

    initial begin
        t_reset;
        t_quick_done;
        t_keep_polling;
        t_confirm_ok;
        t_fail;
        t_host_tmo;
        t_busy_start;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule